// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block settles the outcome of the conditional relative jumps of an 8-bit accumulator CPU. Each accepted request carries a branch kind, the accumulator, an operand byte read from a register or memory, an immediate byte, a signed displacement and the address of the next instruction. One cycle later it returns whether the jump is taken, the jump destination, the decremented operand for loop-counting branches and the carry result of compare branches.

The CPU has no zero status bit, so the zero tests look at the accumulator itself. The destination is the next-instruction address plus the sign-extended displacement, which gives a reach of 128 bytes back and 127 bytes forward, with wrap at the top of the 16-bit space. Fetching, operand addressing and write-back stay with the surrounding pipeline.

Top module: `cbr_eval`

## Requirements
- R1: The destination equals the next-instruction address plus the displacement sign-extended to the address width, modulo 2^16.
- R2: Kind 0 (jump if zero) is taken exactly when the accumulator is 00h; kind 1 (jump if not zero) exactly when it is not.
- R3: Kind 2 (decrement and jump if not zero) returns the operand minus one as the new byte, and is taken exactly when that result is nonzero; an operand of 00h gives FFh and a taken branch.
- R4: Kind 3 compares the accumulator with the operand byte, kind 4 compares the operand byte with the immediate; either is taken exactly when the two bytes differ.
- R5: For kinds 3 and 4 the carry output is 1 when the first byte is below the second as unsigned numbers and 0 otherwise, whether or not the jump is taken.
- R6: For kinds 0, 1 and 2 the carry output equals the carry input of the same request, and for kinds other than 2 the new byte equals the operand byte.
- R7: Every request accepted with the input valid high produces exactly one output-valid pulse in the next cycle, and no pulse appears otherwise; kinds 5 to 7 are never taken.
- R8: A counter loaded with N (1 to 255) and closed by kind 2 branches is taken N-1 times and falls through on the Nth evaluation.
- R9: After reset the output valid and taken flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request valid |
| in_kind | input | 3 | Branch kind code |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Register or memory operand byte |
| in_imm | input | 8 | Immediate byte |
| in_disp | input | 8 | Signed displacement |
| in_next_pc | input | 16 | Address of the following instruction |
| in_cy | input | 1 | Current carry flag |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_taken | output | 1 | Branch taken |
| out_target | output | 16 | Branch destination |
| out_newbyte | output | 8 | Byte to write back |
| out_cy | output | 1 | Resulting carry flag |

## Verification
The bench builds the block with its default 8-bit data and 16-bit address widths, the only combination the CPU uses. These make every displacement and every byte pair reachable, so random traffic hits wrap at both ends of the address space, the 00h decrement and the equal-byte compares, while directed loops with N of 1, 10 and 255 walk the counter through its full range.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    K_ACC_ZERO = 3'd0,
    K_ACC_NZ   = 3'd1,
    K_DEC_NZ   = 3'd2,
    K_CMP_ACC  = 3'd3,
    K_CMP_IMM  = 3'd4
  } kind_e;
endpackage

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] next_pc,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] target
);
  localparam int EXT = AW - DW;

  function automatic logic [AW-1:0] rel_add(input logic [AW-1:0] pc, input logic [DW-1:0] d);
    logic [AW-1:0] sx;
    sx = {{EXT{d[DW-1]}}, d};
    return pc + sx;
  endfunction

  assign target = rel_add(next_pc, disp);
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    kind,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] imm,
  input  logic          cy_in,
  output logic          taken,
  output logic [DW-1:0] newbyte,
  output logic          cy_out,
  output logic          is_cmp
);
  logic [DW-1:0] cmp_a, cmp_b, dec_val;
  logic          acc_zero;

  function automatic logic [DW-1:0] dec_byte(input logic [DW-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic below(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a < b;
  endfunction

  assign acc_zero = (acc == '0);
  assign dec_val  = dec_byte(opnd);
  assign is_cmp   = (kind == K_CMP_ACC) || (kind == K_CMP_IMM);
  assign cmp_a    = (kind == K_CMP_ACC) ? acc  : opnd;
  assign cmp_b    = (kind == K_CMP_ACC) ? opnd : imm;

  always_comb begin
    taken   = 1'b0;
    newbyte = opnd;
    cy_out  = cy_in;
    case (kind)
      K_ACC_ZERO: taken = acc_zero;
      K_ACC_NZ:   taken = !acc_zero;
      K_DEC_NZ: begin
        newbyte = dec_val;
        taken   = (dec_val != '0);
      end
      K_CMP_ACC, K_CMP_IMM: begin
        taken  = (cmp_a != cmp_b);
        cy_out = below(cmp_a, cmp_b);
      end
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
  import cbr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [2:0]    in_kind,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_opnd,
  input  logic [DW-1:0] in_imm,
  input  logic [DW-1:0] in_disp,
  input  logic [AW-1:0] in_next_pc,
  input  logic          in_cy,
  output logic          out_vld,
  output logic          out_taken,
  output logic [AW-1:0] out_target,
  output logic [DW-1:0] out_newbyte,
  output logic          out_cy
);
  logic          c_taken, c_cy, c_cmp;
  logic [DW-1:0] c_newbyte;
  logic [AW-1:0] c_target;

  cbr_target #(.AW(AW), .DW(DW)) u_tgt (
    .next_pc(in_next_pc), .disp(in_disp), .target(c_target)
  );

  cbr_cond #(.DW(DW)) u_cond (
    .kind(in_kind), .acc(in_acc), .opnd(in_opnd), .imm(in_imm), .cy_in(in_cy),
    .taken(c_taken), .newbyte(c_newbyte), .cy_out(c_cy), .is_cmp(c_cmp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld     <= 1'b0;
      out_taken   <= 1'b0;
      out_target  <= '0;
      out_newbyte <= '0;
      out_cy      <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_taken   <= c_taken;
        out_target  <= c_target;
        out_newbyte <= c_newbyte;
        out_cy      <= c_cy;
      end else begin
        out_taken <= 1'b0;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld) else $error("vld"); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld) else $error("spurious"); // R7
  AST_TAKEN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_taken |-> out_vld) else $error("taken"); // R7
  AST_CY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !c_cmp) |=> (out_cy == $past(in_cy))) else $error("cy"); // R6
  AST_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_kind == K_DEC_NZ && in_opnd == 8'h01) |=> !out_taken) else $error("dec"); // R3
  AST_CMP_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && c_cmp && in_opnd == ((in_kind == K_CMP_ACC) ? in_acc : in_imm)) |=> (!out_taken && !out_cy)) else $error("cmp"); // R4
endmodule

// File: tb/sim_cbr_eval.sv
`timescale 1ns/1ps
module sim_cbr_eval;
  logic clk = 0, rst_n = 0, in_vld = 0, in_cy = 0;
  logic [2:0] in_kind = 0;
  logic [7:0] in_acc = 0, in_opnd = 0, in_imm = 0, in_disp = 0;
  logic [15:0] in_next_pc = 0;
  logic out_vld, out_taken, out_cy;
  logic [15:0] out_target;
  logic [7:0] out_newbyte;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cbr_eval u0 (.*);

  function automatic logic [15:0] exp_tgt(input logic [15:0] pc, input logic [7:0] d);
    int s;
    s = (d >= 128) ? int'(d) - 256 : int'(d);
    return 16'((int'(pc) + s + 65536) % 65536);
  endfunction

  function automatic logic exp_taken(input logic [2:0] k, input logic [7:0] a, o, i);
    case (k)
      0: return a == 0;
      1: return a != 0;
      2: return o != 8'd1;
      3: return a != o;
      4: return o != i;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_cy(input logic [2:0] k, input logic [7:0] a, o, i, input logic c);
    if (k == 3) return int'(a) < int'(o);
    if (k == 4) return int'(o) < int'(i);
    return c;
  endfunction

  function automatic logic [7:0] exp_nb(input logic [2:0] k, input logic [7:0] o);
    return (k == 2) ? ((o == 0) ? 8'd255 : o - 8'd1) : o;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [7:0] a, o, i, d,
                       input logic [15:0] pc, input logic c);
    @(negedge clk);
    in_vld = 1; in_kind = k; in_acc = a; in_opnd = o; in_imm = i;
    in_disp = d; in_next_pc = pc; in_cy = c;
    @(negedge clk);
    in_vld = 0;
    chk("R7 vld", out_vld, 1);
    chk("R1 target", out_target, exp_tgt(pc, d));
    chk(k == 2 ? "R3 taken" : (k >= 3 && k <= 4) ? "R4 taken" : "R2 taken",
        out_taken, exp_taken(k, a, o, i));
    chk(k >= 3 && k <= 4 ? "R5 carry" : "R6 carry", out_cy, exp_cy(k, a, o, i, c));
    chk(k == 2 ? "R3 newbyte" : "R6 newbyte", out_newbyte, exp_nb(k, o));
  endtask

  task automatic loop_run(input int n);
    logic [7:0] cnt;
    int tk;
    cnt = 8'(n); tk = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_vld = 1; in_kind = 2; in_opnd = cnt;
      @(negedge clk);
      in_vld = 0;
      if (out_taken) tk++;
      cnt = out_newbyte;
    end
    chk("R8 loop taken count", tk, n - 1);
    chk("R8 final count", cnt, 0);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset vld", out_vld, 0);
    chk("R9 reset taken", out_taken, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 idle", out_vld, 0);
    issue(0, 8'h00, 8'h12, 0, 8'h80, 16'h0010, 1);   // R1 wrap below 0
    issue(1, 8'h00, 0, 0, 8'h7F, 16'hFFF0, 0);        // R1 wrap above top
    issue(2, 0, 8'h00, 0, 8'hFE, 16'h1234, 1);        // R3 00h -> FFh taken
    issue(2, 0, 8'h01, 0, 8'h05, 16'h1234, 0);        // R3 falls through
    issue(3, 8'h2A, 8'h2A, 0, 8'h02, 16'h0100, 1);    // R4 equal
    issue(4, 0, 8'h2E, 8'h2A, 8'h02, 16'h0100, 1);    // R5 greater, clear
    issue(4, 0, 8'h05, 8'hF0, 8'h02, 16'h0100, 0);    // R5 less, set
    issue(6, 8'h00, 8'h00, 0, 8'h02, 16'h0100, 1);    // R7 unused kind
    for (int n = 0; n < 300; n++)
      issue(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom) & (($urandom & 3) == 0 ? 8'h03 : 8'hFF),
            8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
    loop_run(1);
    loop_run(10);
    loop_run(255);
    @(negedge clk);
    chk("R7 no extra pulse", out_vld, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule